// File: doc/BRIEF.md
# Thermometer-to-Binary Encoder With Bubble Suppression

This block sits behind the comparator bank of a flash converter. A converter of `CODE_W` output bits has `2^CODE_W - 1` comparators. Each sample arrives from that bank as a thermometer vector. When the input is clean, the vector is a run of ones from position 0 up to the input level, with zeros above it. Fast input slew or skew between comparator paths can leave stray ones above zeros. These stray ones are called bubbles.

The block compares every position with the position under it and the position over it. A position marks the top of the column only if the position under it and the position itself are both one and the position over it is zero. Under this rule a lone stray one cannot raise a term. The marked positions are then encoded to binary, and the highest one wins. Errors two or more bits wide are not removed. The block reports them with a flag instead.

The code and the flag are registered. They appear one cycle after the valid strobe and hold their values until the next valid sample. The comparators, the reference ladder and the sampling are outside the block.

Top module: `thermo_binary_encoder`

## Requirements
- R1: During and right after a synchronous active-high reset, `out_valid`, `code_out` and `bubble_out` are all 0.
- R2: `out_valid` is 1 in exactly the cycle after a cycle in which `in_valid` was 1 at the clock edge, and 0 otherwise.
- R3: For a clean vector (ones in bits 0..k-1 and zeros above them), `code_out` equals k and `bubble_out` is 0.
- R4: An all-zero vector gives code 0. An all-ones vector gives full scale `2^CODE_W - 1`.
- R5: At the edges, the missing neighbour under bit 0 counts as 1 and the missing neighbour over the top bit counts as 0. So bit 0 alone gives code 1, and the top bit alone gives code 0.
- R6: A single stray one that has a zero under it raises no term. It does not change the code, which is set by the clean part underneath.
- R7: A single zero inside a run of ones raises two terms. The code is the higher term position plus one.
- R8: A stray group of two or more ones, or a gap of two or more zeros between ones, is not removed. The highest raised term sets the code.
- R9: `bubble_out` is 1 exactly when some bit is 1 while the bit directly under it is 0. This covers every sample that raises more than one term.
- R10: While `in_valid` is 0, `code_out` and `bubble_out` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe that qualifies `thermo_in` |
| thermo_in | input | 2^CODE_W-1 | Comparator outputs; bit 0 is the lowest level |
| out_valid | output | 1 | Registered valid, one cycle after `in_valid` |
| code_out | output | CODE_W | Registered binary code |
| bubble_out | output | 1 | Registered flag: bubbles in the sample |

## Verification
Term suppression and highest-term selection can act on the same sample. A vector with a one-bit hole and a lone stray one higher up triggers both. The code must follow the upper edge of the hole and ignore the stray one, and the flag must rise. The same sample also checks the boundary rules, because the stray one may sit at the top bit. Expected codes come from the neighbour rule in the requirements. These vectors are sent back-to-back and with idle gaps, so updates and holds are both observed.

// File: rtl/thermo_enc_pkg.sv
package thermo_enc_pkg;

  // Number of comparator taps for a code of width w.
  function automatic int unsigned tap_count(input int unsigned w);
    return (32'd1 << w) - 32'd1;
  endfunction

  typedef struct packed {
    logic valid;
    logic bubble;
  } enc_flags_t;

endpackage

// File: rtl/thermo_edge_detect.sv
module thermo_edge_detect #(
  parameter int unsigned TAPS = 15
) (
  input  logic [TAPS-1:0] level,
  output logic [TAPS-1:0] edge_hit
);

  for (genvar i = 0; i < TAPS; i++) begin : g_pos
    logic lower;
    logic upper;
    if (i == 0) begin : g_bottom
      assign lower = 1'b1;
    end else begin : g_lower
      assign lower = level[i-1];
    end
    if (i == TAPS - 1) begin : g_top
      assign upper = 1'b0;
    end else begin : g_upper
      assign upper = level[i+1];
    end
    assign edge_hit[i] = lower & level[i] & ~upper;
  end

endmodule

// File: rtl/thermo_bubble_detect.sv
module thermo_bubble_detect #(
  parameter int unsigned TAPS = 15
) (
  input  logic [TAPS-1:0] level,
  output logic            bubble
);

  logic [TAPS-1:0] rise_up;

  for (genvar i = 0; i < TAPS; i++) begin : g_rise
    if (i == 0) begin : g_base
      assign rise_up[i] = 1'b0;
    end else begin : g_step
      assign rise_up[i] = level[i] & ~level[i-1];
    end
  end

  assign bubble = |rise_up;

endmodule

// File: rtl/top_hit_encoder.sv
module top_hit_encoder #(
  parameter int unsigned TAPS   = 15,
  parameter int unsigned CODE_W = 4
) (
  input  logic [TAPS-1:0]   hits,
  output logic [CODE_W-1:0] code
);

  always_comb begin
    code = '0;
    for (int i = 0; i < TAPS; i++) begin
      if (hits[i]) begin
        code = CODE_W'(i + 1);
      end
    end
  end

endmodule

// File: rtl/thermo_binary_encoder.sv
module thermo_binary_encoder #(
  parameter int unsigned CODE_W = 4,
  localparam int unsigned TAPS  = thermo_enc_pkg::tap_count(CODE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [TAPS-1:0]   thermo_in,
  output logic              out_valid,
  output logic [CODE_W-1:0] code_out,
  output logic              bubble_out
);

  import thermo_enc_pkg::*;

  logic [TAPS-1:0]   edge_hit;
  logic [CODE_W-1:0] code_nxt;
  logic              bubble_nxt;
  enc_flags_t        flags_q;
  logic [CODE_W-1:0] code_q;

  thermo_edge_detect #(.TAPS(TAPS)) u_edge (
    .level    (thermo_in),
    .edge_hit (edge_hit)
  );

  thermo_bubble_detect #(.TAPS(TAPS)) u_bubble (
    .level  (thermo_in),
    .bubble (bubble_nxt)
  );

  top_hit_encoder #(.TAPS(TAPS), .CODE_W(CODE_W)) u_enc (
    .hits (edge_hit),
    .code (code_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      code_q  <= '0;
    end else begin
      flags_q.valid <= in_valid;
      if (in_valid) begin
        code_q         <= code_nxt;
        flags_q.bubble <= bubble_nxt;
      end
    end
  end

  assign out_valid  = flags_q.valid;
  assign code_out   = code_q;
  assign bubble_out = flags_q.bubble;

endmodule

// File: rtl/thermo_binary_encoder_chk.sv
module thermo_binary_encoder_chk #(
  parameter int unsigned CODE_W = 4,
  localparam int unsigned TAPS  = thermo_enc_pkg::tap_count(CODE_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [TAPS-1:0]   thermo_in,
  input logic              out_valid,
  input logic [CODE_W-1:0] code_out,
  input logic              bubble_out
);

  logic [TAPS-1:0] next_up;
  logic            clean;
  assign next_up = thermo_in + 1'b1;
  assign clean   = ((thermo_in & next_up) == '0);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_clean_count_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && clean) |=> ((code_out == CODE_W'($countones($past(thermo_in)))) && !bubble_out));

  assert_full_scale_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (&thermo_in)) |=> (&code_out));

  assert_zero_input_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (thermo_in == '0)) |=> (code_out == '0));

  assert_flag_on_bubble_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !clean) |=> bubble_out);

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(code_out) && $stable(bubble_out)));

endmodule

bind thermo_binary_encoder thermo_binary_encoder_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .thermo_in  (thermo_in),
  .out_valid  (out_valid),
  .code_out   (code_out),
  .bubble_out (bubble_out)
);

// File: tb/test_thermo_binary_encoder.sv
module test_thermo_binary_encoder;

  localparam int unsigned CW   = 4;
  localparam int unsigned TAPS = (1 << CW) - 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [TAPS-1:0] thermo_in = '0;
  logic            out_valid;
  logic [CW-1:0]   code_out;
  logic            bubble_out;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [CW-1:0] code;
    logic          bubble;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  logic exp_ov = 1'b0;
  logic seen_any = 1'b0;
  logic [CW-1:0] last_code = '0;
  logic last_bub = 1'b0;

  always #2.5 clk = ~clk;

  thermo_binary_encoder #(.CODE_W(CW)) i_thermo_binary_encoder (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .thermo_in  (thermo_in),
    .out_valid  (out_valid),
    .code_out   (code_out),
    .bubble_out (bubble_out)
  );

  // Reference from the requirements: neighbour rule with 1 under bit 0
  // and 0 over the top bit; highest term wins; flag on any upward 0->1 step.
  function automatic exp_t model(input logic [TAPS-1:0] v, input string tag);
    exp_t e;
    e.code = '0;
    e.bubble = 1'b0;
    e.tag = tag;
    for (int i = 0; i < TAPS; i++) begin
      logic lo, hi;
      lo = (i == 0) ? 1'b1 : v[i-1];
      hi = (i == TAPS - 1) ? 1'b0 : v[i+1];
      if (lo && v[i] && !hi) e.code = CW'(i + 1);
      if (i > 0 && v[i] && !v[i-1]) e.bubble = 1'b1;
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic send(input logic [TAPS-1:0] v, input string tag);
    @(negedge clk);
    in_valid  = 1'b1;
    thermo_in = v;
    exp_q.push_back(model(v, tag));
  endtask

  task automatic send_with(input logic [TAPS-1:0] v, input int code, input bit bub, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid  = 1'b1;
    thermo_in = v;
    e.code = CW'(code);
    e.bubble = bub;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n, input logic [TAPS-1:0] junk);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid  = 1'b0;
      thermo_in = junk;
    end
  endtask

  always @(posedge clk) begin
    if (rst) exp_ov <= 1'b0;
    else     exp_ov <= in_valid;
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(out_valid == exp_ov, "R2 out_valid", int'(out_valid), int'(exp_ov));
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(code_out == e.code, {e.tag, " code"}, int'(code_out), int'(e.code));
          check(bubble_out == e.bubble, {"R9 flag for ", e.tag}, int'(bubble_out), int'(e.bubble));
        end
        seen_any  <= 1'b1;
        last_code <= code_out;
        last_bub  <= bubble_out;
      end else if (seen_any) begin
        check(code_out == last_code, "R10 code held", int'(code_out), int'(last_code));
        check(bubble_out == last_bub, "R10 flag held", int'(bubble_out), int'(last_bub));
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(code_out == '0, "R1 code", int'(code_out), 0);
    check(bubble_out == 1'b0, "R1 flag", int'(bubble_out), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 after reset", int'(out_valid), 0);

    // R3 every clean level, back-to-back
    for (int k = 0; k <= TAPS; k++) begin
      logic [TAPS-1:0] v;
      v = TAPS'((32'd1 << k) - 1);
      send_with(v, k, 1'b0, "R3");
    end
    idle(3, 15'h5555);

    // R4 extremes, R5 boundaries
    send_with(15'h0000, 0, 1'b0, "R4 zero");
    send_with(15'h7FFF, 15, 1'b0, "R4 full");
    idle(2, 15'h7FFF);
    send_with(15'h0001, 1, 1'b0, "R5 bottom");
    send_with(15'h4000, 0, 1'b1, "R5 top lone");
    send_with(15'h6000, 15, 1'b1, "R5 top pair");

    // R6 isolated stray one suppressed
    send_with(15'h0047, 3, 1'b1, "R6");
    send_with(15'h0010, 0, 1'b1, "R6 mid lone");
    idle(2, 15'h0000);

    // R7 single hole
    send_with(15'h003B, 6, 1'b1, "R7");
    // R8 wider errors
    send_with(15'h0063, 7, 1'b1, "R8 pair");
    send_with(15'h00F3, 8, 1'b1, "R8 gap");
    // Hole plus suppressed stray one in one sample
    send_with(15'h009B, 5, 1'b1, "R6 R7 combined");
    send_with(15'h401B, 5, 1'b1, "R5 R7 combined");

    // Sweep of mixed patterns against the model
    for (int k = 0; k < 40; k++) begin
      logic [TAPS-1:0] v;
      v = TAPS'((k * 32'h2F1D) ^ (k << 5));
      send(v, "R9 sweep");
      if (k % 7 == 3) idle(1, ~v);
    end
    idle(4, 15'h1234);

    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule